// File: doc/BRIEF.md
# LPC Memory Read Initiator

This block is the host end of a single-byte memory read on the LPC bus. A user asserts a one-cycle request together with a 32-bit address. The block then walks the bus through its field sequence: the start nibble with the frame strobe low, the memory-read cycle type, eight address nibbles, and the host-to-target turnaround. It waits a bounded number of clocks for the target's ready code and captures two data nibbles. Finally it hands the bus back with a second turnaround.

The assembled byte is reported with a one-cycle completion pulse. If the target never signals ready, the block pulses an error output. It then holds the frame strobe low for a few clocks to abort the cycle and returns to idle. The LAD pins are modelled as a drive value, a drive enable and a sampled input, so the pad logic stays outside the block.

Top module: `lpc_rd_init`

## Requirements
- R1: After reset and whenever no transfer is in progress, `frame_n_o` is 1, `lad_oe_o` is 0, `done_o`, `err_o` and `busy_o` are 0.
- R2: In the clock after a request is accepted in idle, `frame_n_o` is 0 and LAD is driven with 0000. `busy_o` is 1 from this clock until the block is idle again.
- R3: The clock after the start nibble drives LAD = 0100 (memory read, reserved bit 0) with `frame_n_o` back at 1. The strobe is low for the start clock only.
- R4: The next eight clocks drive the address one nibble per clock, bits [31:28] first and bits [3:0] last.
- R5: Each turnaround drives LAD = 1111 for one clock and releases LAD (`lad_oe_o` = 0) in the following clock.
- R6: After the first turnaround, LAD stays released and is sampled once per clock for up to WAIT_LIMIT clocks. Any nonzero value means keep waiting. The value 0000 means the first data nibble is on the next clock.
- R7: The first data nibble becomes `data_o[3:0]` and the second becomes `data_o[7:4]`. `data_o` holds the byte while `done_o` is 1.
- R8: `done_o` is a one-cycle pulse in the clock right after the second data nibble. In that same clock the host drives 1111. LAD is released on the next clock, and the block is idle one clock later. `done_o` and `err_o` are never both 1.
- R9: If no 0000 is sampled in WAIT_LIMIT clocks, `err_o` pulses for one clock. `frame_n_o` is held 0 with LAD released for ABORT_CLKS clocks, starting with the error clock. The block then goes idle without raising `done_o`.
- R10: A request raised while `busy_o` is 1 is ignored. It does not change the address being sent and does not start a further transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle read request, honoured only in idle |
| addr_i | input | 32 | Byte address, sampled with the accepted request |
| lad_i | input | 4 | Sampled LAD pins |
| frame_n_o | output | 1 | Active-low frame strobe |
| lad_o | output | 4 | LAD drive value |
| lad_oe_o | output | 1 | LAD drive enable |
| data_o | output | 8 | Captured read byte |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle no-response pulse |
| busy_o | output | 1 | Transfer in progress |

## Verification
Every one of the 256 data bytes is read back, with the target's ready delay swept across the whole allowed window. This separates a swapped or mis-latched nibble from correct assembly, and an early or late data capture from correct sync handling. Walking-one and all-ones address patterns expose any nibble ordering or index error in the address phase, since each position is isolated. Delays at and beyond the window limit separate the last legal wait from a timeout. A read issued after each abort shows the block recovers cleanly. Requests pulsed during transfers, carrying the complemented address, reveal whether a busy-time request leaks into the address or starts a second cycle.

// File: rtl/lpc_rd_pkg.sv
package lpc_rd_pkg;

    localparam int ADDR_W    = 32;
    localparam int NIB_W     = 4;
    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int BYTE_W    = 2 * NIB_W;

    localparam logic [NIB_W-1:0] NIB_START = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_MEMRD = 4'b0100;
    localparam logic [NIB_W-1:0] NIB_TURN  = 4'b1111;
    localparam logic [NIB_W-1:0] NIB_READY = 4'b0000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_CTYPE,
        ST_ADDR,
        ST_TAR_H0,
        ST_TAR_H1,
        ST_SYNC,
        ST_DLO,
        ST_DHI,
        ST_TAR_R0,
        ST_TAR_R1,
        ST_ABORT
    } lpc_st_e;

    typedef struct packed {
        logic             frame_n;
        logic             oe;
        logic [NIB_W-1:0] lad;
    } lpc_bus_t;

    // Nibble idx of the address, counted from the most significant end.
    function automatic logic [NIB_W-1:0] addr_nibble(input logic [ADDR_W-1:0] a,
                                                     input int idx);
        return a[ADDR_W - NIB_W - NIB_W*idx +: NIB_W];
    endfunction

endpackage

// File: rtl/lpc_rd_seq.sv
module lpc_rd_seq
    import lpc_rd_pkg::*;
#(
    parameter int WAIT_LIMIT = 16,
    parameter int ABORT_CLKS = 4,
    localparam int MAXC = (WAIT_LIMIT > ABORT_CLKS) ?
                          ((WAIT_LIMIT > ADDR_NIBS) ? WAIT_LIMIT : ADDR_NIBS) :
                          ((ABORT_CLKS > ADDR_NIBS) ? ABORT_CLKS : ADDR_NIBS),
    localparam int CW = $clog2(MAXC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NIB_W-1:0]  lad_in,
    output lpc_st_e           st,
    output logic [CW-1:0]     cnt,
    output logic [ADDR_W-1:0] addr_q,
    output logic              done,
    output logic              err
);

    localparam logic [CW-1:0] LAST_NIB   = CW'(ADDR_NIBS - 1);
    localparam logic [CW-1:0] LAST_WAIT  = CW'(WAIT_LIMIT - 1);
    localparam logic [CW-1:0] LAST_ABORT = CW'(ABORT_CLKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req) begin
                        addr_q <= addr;
                        st     <= ST_START;
                    end
                end
                ST_START:  st <= ST_CTYPE;
                ST_CTYPE: begin
                    st  <= ST_ADDR;
                    cnt <= '0;
                end
                ST_ADDR: begin
                    if (cnt == LAST_NIB) st <= ST_TAR_H0;
                    else                 cnt <= cnt + 1'b1;
                end
                ST_TAR_H0: st <= ST_TAR_H1;
                ST_TAR_H1: begin
                    st  <= ST_SYNC;
                    cnt <= '0;
                end
                ST_SYNC: begin
                    if (lad_in == NIB_READY) begin
                        st <= ST_DLO;
                    end else if (cnt == LAST_WAIT) begin
                        st  <= ST_ABORT;
                        err <= 1'b1;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DLO: st <= ST_DHI;
                ST_DHI: begin
                    st   <= ST_TAR_R0;
                    done <= 1'b1;
                end
                ST_TAR_R0: st <= ST_TAR_R1;
                ST_TAR_R1: st <= ST_IDLE;
                ST_ABORT: begin
                    if (cnt == LAST_ABORT) st <= ST_IDLE;
                    else                   cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lpc_rd_drive.sv
module lpc_rd_drive
    import lpc_rd_pkg::*;
#(
    parameter int CW = 4
) (
    input  lpc_st_e           st,
    input  logic [CW-1:0]     cnt,
    input  logic [ADDR_W-1:0] addr_q,
    output lpc_bus_t          bus
);

    always_comb begin
        bus = '{frame_n: 1'b1, oe: 1'b0, lad: NIB_TURN};
        case (st)
            ST_START: begin
                bus.frame_n = 1'b0;
                bus.oe      = 1'b1;
                bus.lad     = NIB_START;
            end
            ST_CTYPE: begin
                bus.oe  = 1'b1;
                bus.lad = NIB_MEMRD;
            end
            ST_ADDR: begin
                bus.oe  = 1'b1;
                bus.lad = addr_nibble(addr_q, int'(cnt));
            end
            ST_TAR_H0, ST_TAR_R0: begin
                bus.oe  = 1'b1;
                bus.lad = NIB_TURN;
            end
            ST_ABORT: bus.frame_n = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/lpc_rd_capture.sv
module lpc_rd_capture
    import lpc_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lpc_st_e           st,
    input  logic [NIB_W-1:0]  lad_in,
    output logic [BYTE_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (st == ST_DLO) begin
            data[NIB_W-1:0] <= lad_in;
        end else if (st == ST_DHI) begin
            data[BYTE_W-1:NIB_W] <= lad_in;
        end
    end

endmodule

// File: rtl/lpc_rd_init.sv
module lpc_rd_init
    import lpc_rd_pkg::*;
#(
    parameter int WAIT_LIMIT = 16,
    parameter int ABORT_CLKS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  logic [31:0] addr_i,
    input  logic [3:0]  lad_i,
    output logic        frame_n_o,
    output logic [3:0]  lad_o,
    output logic        lad_oe_o,
    output logic [7:0]  data_o,
    output logic        done_o,
    output logic        err_o,
    output logic        busy_o
);

    localparam int MAXC = (WAIT_LIMIT > ABORT_CLKS) ?
                          ((WAIT_LIMIT > ADDR_NIBS) ? WAIT_LIMIT : ADDR_NIBS) :
                          ((ABORT_CLKS > ADDR_NIBS) ? ABORT_CLKS : ADDR_NIBS);
    localparam int CW = $clog2(MAXC + 1);

    lpc_st_e           st;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] addr_q;
    lpc_bus_t          bus;

    lpc_rd_seq #(
        .WAIT_LIMIT (WAIT_LIMIT),
        .ABORT_CLKS (ABORT_CLKS)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (req_i),
        .addr   (addr_i),
        .lad_in (lad_i),
        .st     (st),
        .cnt    (cnt),
        .addr_q (addr_q),
        .done   (done_o),
        .err    (err_o)
    );

    lpc_rd_drive #(
        .CW (CW)
    ) u_drive (
        .st     (st),
        .cnt    (cnt),
        .addr_q (addr_q),
        .bus    (bus)
    );

    lpc_rd_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .st     (st),
        .lad_in (lad_i),
        .data   (data_o)
    );

    assign frame_n_o = bus.frame_n;
    assign lad_oe_o  = bus.oe;
    assign lad_o     = bus.lad;
    assign busy_o    = (st != ST_IDLE);

endmodule

// File: rtl/lpc_rd_init_chk.sv
module lpc_rd_init_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_n_o,
    input logic [3:0] lad_o,
    input logic       lad_oe_o,
    input logic       done_o,
    input logic       err_o,
    input logic       busy_o
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (frame_n_o && !lad_oe_o && !done_o && !err_o)); // R1

    AST_START_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (!frame_n_o && lad_oe_o && lad_o == 4'b0000)); // R2

    AST_CTYPE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |=> (frame_n_o && lad_oe_o && lad_o == 4'b0100)); // R3

    AST_DONE_TURN: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lad_oe_o && lad_o == 4'b1111)); // R8

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!lad_oe_o && busy_o && !done_o)); // R5

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o)); // R8

    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!frame_n_o && !lad_oe_o)); // R9

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o); // R9

endmodule

bind lpc_rd_init lpc_rd_init_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_n_o (frame_n_o),
    .lad_o     (lad_o),
    .lad_oe_o  (lad_oe_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .busy_o    (busy_o)
);

// File: tb/lpc_rd_init_bench.sv
module lpc_rd_init_bench;

    localparam int WL = 4;
    localparam int AC = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [3:0]  lad_i = 4'hF;
    logic        frame_n_o;
    logic [3:0]  lad_o;
    logic        lad_oe_o;
    logic [7:0]  data_o;
    logic        done_o;
    logic        err_o;
    logic        busy_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lpc_rd_init #(
        .WAIT_LIMIT (WL),
        .ABORT_CLKS (AC)
    ) u_lpc_rd_init (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .addr_i    (addr_i),
        .lad_i     (lad_i),
        .frame_n_o (frame_n_o),
        .lad_o     (lad_o),
        .lad_oe_o  (lad_oe_o),
        .data_o    (data_o),
        .done_o    (done_o),
        .err_o     (err_o),
        .busy_o    (busy_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(frame_n_o && !lad_oe_o && !done_o && !err_o && !busy_o, tag,
            {27'd0, frame_n_o, lad_oe_o, done_o, err_o, busy_o}, 32'h10);
    endtask

    // One read; dly = clocks of nonzero wait before ready (>= WL means timeout).
    task automatic do_read(input logic [31:0] a, input logic [7:0] b,
                           input int dly, input bit poke);
        @(negedge clk);
        req_i  = 1'b1;
        addr_i = a;
        @(negedge clk);
        req_i = 1'b0;
        chk(!frame_n_o && lad_oe_o && lad_o == 4'h0 && busy_o, "R2 start",
            {26'd0, frame_n_o, lad_oe_o, lad_o}, 32'h10);
        if (poke) begin
            req_i  = 1'b1;
            addr_i = ~a;
        end
        @(negedge clk);
        req_i = 1'b0;
        chk(frame_n_o && lad_oe_o && lad_o == 4'b0100, "R3 cycle type",
            {26'd0, frame_n_o, lad_oe_o, lad_o}, 32'h34);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(frame_n_o && lad_oe_o && lad_o == a[31-4*i -: 4],
                poke ? "R10 address kept" : "R4 address nibble",
                {26'd0, frame_n_o, lad_oe_o, lad_o}, {26'd0, 2'b11, a[31-4*i -: 4]});
        end
        @(negedge clk);
        chk(lad_oe_o && lad_o == 4'hF, "R5 host turn drive",
            {27'd0, lad_oe_o, lad_o}, 32'h1F);
        @(negedge clk);
        chk(!lad_oe_o, "R5 host turn float", {31'd0, lad_oe_o}, 32'h0);
        for (int k = 0; k < WL; k++) begin
            @(negedge clk);
            chk(!lad_oe_o && frame_n_o && busy_o && !err_o, "R6 sync wait released",
                {29'd0, lad_oe_o, frame_n_o, err_o}, 32'h2);
            lad_i = (k == dly) ? 4'h0 : 4'((k + dly) % 15 + 1);
            if (k == dly) break;
        end
        if (dly < WL) begin
            @(negedge clk);
            chk(!lad_oe_o && !done_o && !err_o, "R6 data after ready",
                {29'd0, lad_oe_o, done_o, err_o}, 32'h0);
            lad_i = b[3:0];
            @(negedge clk);
            chk(!lad_oe_o && !done_o, "R6 second data clock",
                {30'd0, lad_oe_o, done_o}, 32'h0);
            lad_i = b[7:4];
            @(negedge clk);
            lad_i = 4'hF;
            chk(done_o && !err_o, "R8 done pulse", {30'd0, done_o, err_o}, 32'h2);
            chk(data_o == b, "R7 byte assembly", {24'd0, data_o}, {24'd0, b});
            chk(lad_oe_o && lad_o == 4'hF, "R8 return turn drive",
                {27'd0, lad_oe_o, lad_o}, 32'h1F);
            @(negedge clk);
            chk(!done_o && !lad_oe_o && busy_o, "R5 return turn float",
                {29'd0, done_o, lad_oe_o, busy_o}, 32'h1);
            @(negedge clk);
            chk_idle("R8 idle after read");
        end else begin
            @(negedge clk);
            lad_i = 4'hF;
            chk(err_o && !done_o && !frame_n_o && !lad_oe_o, "R9 timeout abort",
                {28'd0, err_o, done_o, frame_n_o, lad_oe_o}, 32'h8);
            for (int j = 1; j < AC; j++) begin
                @(negedge clk);
                chk(!err_o && !done_o && !frame_n_o && !lad_oe_o, "R9 abort hold",
                    {28'd0, err_o, done_o, frame_n_o, lad_oe_o}, 32'h0);
            end
            @(negedge clk);
            chk_idle("R9 idle after abort");
        end
        if (poke) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                chk_idle("R10 no extra transfer");
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1 reset state");
        chk(data_o == 8'h00, "R1 reset data", {24'd0, data_o}, 32'h0);

        for (int d = 0; d < 256; d++) begin
            logic [7:0] bv;
            bv = 8'(d);
            do_read({bv, ~bv, bv ^ 8'h5A, 8'(d * 37)}, bv, d % WL, (d % 7) == 0);
        end

        for (int i = 0; i < 32; i++)
            do_read(32'h1 << i, 8'(i * 9 + 3), WL - 1, 1'b0);
        do_read(32'hFFFF_FFFF, 8'hC3, 0, 1'b1);

        do_read(32'hDEAD_BEEF, 8'h00, WL, 1'b0);
        do_read(32'h0000_0010, 8'hA5, 1, 1'b0);
        do_read(32'h1234_5678, 8'h00, WL + 3, 1'b1);
        do_read(32'h8765_4321, 8'h3C, WL - 1, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule